// File: doc/BRIEF.md
# PCIe Legacy Status Register

This block holds the 16-bit status word of a PCI Express endpoint's configuration header. The transaction layer reports error and completion events to it as single-cycle strobes. The block turns each event into the matching legacy PCI status flag. Some flags are gated by enable bits that come from the command register, which sits outside this block.

The six event flags are sticky. Only hardware events set them. Software clears a flag by writing a 1 to it through a byte-enabled write port. The interrupt-status bit mirrors an internal INTx pending level. Every field that has no meaning on PCI Express is fixed: one reads as 1 and the rest read as 0.

The read value comes straight from registers, so an event shows up on `rd_data` in the cycle after its strobe.

Top module: `pcie_legacy_status`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `rd_data` reads 0x0010 and all sticky flags are cleared.
- R2: Bit 15 sets on a received poisoned TLP (`ev_poison_rx`), whatever the value of `cmd_perr_resp`.
- R3: Bit 14 sets on a sent fatal or non-fatal error message (`ev_errmsg_tx`) only when `cmd_serr_en` is 1 in the same cycle.
- R4: Bit 13 sets on a received completion with Unsupported Request status (`ev_cpl_ur_rx`). Bit 12 sets on a received completion with Completer Abort status (`ev_cpl_ca_rx`).
- R5: Bit 11 sets when this device sends a completion with Completer Abort status (`ev_cpl_ca_tx`).
- R6: Bit 8 sets on either of two events, a poisoned completion for an outbound read (`ev_poison_cpl_rd`) or a poisoned outbound write (`ev_poison_wr_tx`), but only when `cmd_perr_resp` is 1.
- R7: Bit 4 always reads 1. Bits 10:9, 7, 6, 5 and 2:0 always read 0. Writes do not change any of these bits.
- R8: Bit 3 shows the value `intx_pending` had at the previous clock edge. Writes do not affect it.
- R9: Writing a 1 to bit 15, 14, 13, 12, 11 or 8 clears that bit. Writing a 0 leaves it unchanged.
- R10: A write acts only on the bytes whose enable is set. `wr_be[1]` covers bits 15:8 and `wr_be[0]` covers bits 7:0. If `wr_en` is 0, the write does nothing.
- R11: When a set event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R12: Every flag changes at the clock edge where its strobe or write is sampled, and it is visible on `rd_data` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_poison_rx | input | 1 | Poisoned TLP received |
| ev_errmsg_tx | input | 1 | ERR_FATAL or ERR_NONFATAL message sent |
| ev_cpl_ur_rx | input | 1 | Completion received with Unsupported Request status |
| ev_cpl_ca_rx | input | 1 | Completion received with Completer Abort status |
| ev_cpl_ca_tx | input | 1 | Completion sent with Completer Abort status |
| ev_poison_cpl_rd | input | 1 | Poisoned completion received for an outbound read |
| ev_poison_wr_tx | input | 1 | Poisoned TLP sent for an outbound write |
| cmd_serr_en | input | 1 | System-error enable from the command register |
| cmd_perr_resp | input | 1 | Parity-error response enable from the command register |
| intx_pending | input | 1 | Internal INTx pending level |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables for the write |
| wr_data | input | 16 | Write data; a 1 clears the matching sticky flag |
| rd_data | output | 16 | Current register value |

## Verification
The hardest case to reach from the ports is a set event and a clear of the same flag landing on the same clock edge. The bench drives a system-error message with its enable high together with a byte-enabled write of 1 to bit 14, and then checks that the flag is still set.

The bench also pairs a masked write of all ones with a new poisoned-write event. This shows that a byte whose enable is low neither clears a flag nor blocks a set. The gated flags are driven with their enable low first and high afterwards, so that both settings of each gate are observed.

// File: rtl/pcie_stat_pkg.sv
package pcie_stat_pkg;
  localparam int REG_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int BE_W    = REG_W / BYTE_W;
  localparam int NUM_RC  = 6;

  // Positions of the sticky flags; software decodes these offsets.
  localparam int POS_PERR_DET = 15;
  localparam int POS_SERR_SIG = 14;
  localparam int POS_MABT_RX  = 13;
  localparam int POS_TABT_RX  = 12;
  localparam int POS_TABT_TX  = 11;
  localparam int POS_MPERR    = 8;
  localparam int POS_CAP_LIST = 4;
  localparam int POS_INT_STAT = 3;

  localparam int RC_POS [NUM_RC] = '{POS_PERR_DET, POS_SERR_SIG, POS_MABT_RX,
                                     POS_TABT_RX, POS_TABT_TX, POS_MPERR};

  typedef struct packed {
    logic poison_rx;
    logic errmsg_tx;
    logic cpl_ur_rx;
    logic cpl_ca_rx;
    logic cpl_ca_tx;
    logic poison_cpl_rd;
    logic poison_wr_tx;
  } stat_ev_t;
endpackage

// File: rtl/pcie_stat_evmap.sv
module pcie_stat_evmap
  import pcie_stat_pkg::*;
(
  input  stat_ev_t          ev,
  input  logic              serr_en,
  input  logic              perr_resp,
  output logic [NUM_RC-1:0] set_o
);
  // Index order follows RC_POS in the package.
  always_comb begin
    set_o[0] = ev.poison_rx;
    set_o[1] = ev.errmsg_tx & serr_en;
    set_o[2] = ev.cpl_ur_rx;
    set_o[3] = ev.cpl_ca_rx;
    set_o[4] = ev.cpl_ca_tx;
    set_o[5] = (ev.poison_cpl_rd | ev.poison_wr_tx) & perr_resp;
  end
endmodule

// File: rtl/pcie_stat_rc_bit.sv
module pcie_stat_rc_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/pcie_legacy_status.sv
module pcie_legacy_status
  import pcie_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_poison_rx,
  input  logic        ev_errmsg_tx,
  input  logic        ev_cpl_ur_rx,
  input  logic        ev_cpl_ca_rx,
  input  logic        ev_cpl_ca_tx,
  input  logic        ev_poison_cpl_rd,
  input  logic        ev_poison_wr_tx,
  input  logic        cmd_serr_en,
  input  logic        cmd_perr_resp,
  input  logic        intx_pending,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data
);
  stat_ev_t          ev;
  logic [NUM_RC-1:0] set_v;
  logic [NUM_RC-1:0] clr_v;
  logic [NUM_RC-1:0] q_v;
  logic              int_q;

  assign ev = '{poison_rx: ev_poison_rx, errmsg_tx: ev_errmsg_tx,
                cpl_ur_rx: ev_cpl_ur_rx, cpl_ca_rx: ev_cpl_ca_rx,
                cpl_ca_tx: ev_cpl_ca_tx, poison_cpl_rd: ev_poison_cpl_rd,
                poison_wr_tx: ev_poison_wr_tx};

  pcie_stat_evmap u_map (
    .ev        (ev),
    .serr_en   (cmd_serr_en),
    .perr_resp (cmd_perr_resp),
    .set_o     (set_v)
  );

  for (genvar i = 0; i < NUM_RC; i++) begin : g_rc
    localparam int P = RC_POS[i];
    assign clr_v[i] = wr_en & wr_be[P / BYTE_W] & wr_data[P];
    pcie_stat_rc_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (q_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) int_q <= 1'b0;
    else     int_q <= intx_pending;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_RC; k++) rd_data[RC_POS[k]] = q_v[k];
    rd_data[POS_CAP_LIST] = 1'b1;
    rd_data[POS_INT_STAT] = int_q;
  end

  // R7
  fixed_bits_chk: assert property (@(posedge clk)
    !rst |=> (rd_data[4] && rd_data[10:9] == 2'b00 && !rd_data[7] &&
              !rd_data[6] && !rd_data[5] && rd_data[2:0] == 3'b000));
  // R8
  int_follow_chk: assert property (@(posedge clk)
    !rst |=> rd_data[3] == $past(intx_pending));
  // R3
  serr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[14]) |-> $past(ev_errmsg_tx && cmd_serr_en));
  // R6
  mperr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[8]) |-> $past(cmd_perr_resp &&
                                (ev_poison_cpl_rd || ev_poison_wr_tx)));
  // R2
  perr_det_chk: assert property (@(posedge clk) disable iff (rst)
    ev_poison_rx |=> rd_data[15]);
  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !ev_poison_rx) |=> !$fell(rd_data[15]));
endmodule

// File: tb/tb_pcie_legacy_status.sv
`timescale 1ns/1ps
module tb_pcie_legacy_status;
  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  ev;
  logic        serr_en, perr_resp, intx, wr_en;
  logic [1:0]  wr_be;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  pcie_legacy_status dut (
    .clk(clk), .rst(rst),
    .ev_poison_rx(ev[6]), .ev_errmsg_tx(ev[5]), .ev_cpl_ur_rx(ev[4]),
    .ev_cpl_ca_rx(ev[3]), .ev_cpl_ca_tx(ev[2]), .ev_poison_cpl_rd(ev[1]),
    .ev_poison_wr_tx(ev[0]), .cmd_serr_en(serr_en), .cmd_perr_resp(perr_resp),
    .intx_pending(intx), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data)
  );

  // ev bits: {poison_rx, errmsg, ur_rx, ca_rx, ca_tx, poison_cpl_rd, poison_wr_tx}
  // ctl bits: {serr_en, perr_resp, intx, wr_en}
  localparam int NV = 16;
  localparam logic [6:0]  V_EV  [NV] = '{7'h40, 7'h20, 7'h20, 7'h10, 7'h08, 7'h04,
    7'h02, 7'h02, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h20, 7'h01, 7'h00};
  localparam logic [3:0]  V_CTL [NV] = '{4'h0, 4'h0, 4'h8, 4'h0, 4'h0, 4'h0,
    4'h0, 4'h4, 4'h2, 4'h3, 4'h1, 4'h1, 4'h1, 4'h9, 4'h5, 4'h1};
  localparam logic [1:0]  V_BE  [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
    2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b11, 2'b11, 2'b10, 2'b00, 2'b11};
  localparam logic [15:0] V_WD  [NV] = '{16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
    16'h0, 16'h0, 16'h0, 16'hFFFF, 16'h8000, 16'h0100, 16'h0000, 16'h4000,
    16'hFFFF, 16'hFFFF};
  localparam logic [15:0] V_EXP [NV] = '{16'h8010, 16'h8010, 16'hC010, 16'hE010,
    16'hF010, 16'hF810, 16'hF810, 16'hF910, 16'hF918, 16'hF918, 16'h7910,
    16'h7810, 16'h7810, 16'h7810, 16'h7910, 16'h0010};
  // Tags per vector: R2, R3, R3, R4, R4, R5, R6, R6, R8, R10/R7, R9/R10, R9,
  // R9 (zero write), R11, R10/R6, R9/R12
  localparam string V_REQ [NV] = '{"R2", "R3", "R3", "R4", "R4", "R5", "R6",
    "R6", "R8", "R10", "R9", "R9", "R9", "R11", "R10", "R12"};

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic idle();
    ev = '0; serr_en = 0; perr_resp = 0; intx = 0;
    wr_en = 0; wr_be = '0; wr_data = '0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1", 16'h0010);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ev = V_EV[i];
      {serr_en, perr_resp, intx, wr_en} = V_CTL[i];
      wr_be = V_BE[i]; wr_data = V_WD[i];
      @(posedge clk);
      @(negedge clk);
      check(V_REQ[i], V_EXP[i]);
      idle();
    end

    // R7: write 1s to every fixed bit, the low byte included
    wr_en = 1; wr_be = 2'b11; wr_data = 16'h06F7;
    @(posedge clk); @(negedge clk);
    check("R7", 16'h0010);
    idle();

    // R8: bit 3 drops one edge after intx_pending drops
    intx = 1;
    @(posedge clk); @(negedge clk);
    check("R8", 16'h0018);
    intx = 0;
    @(posedge clk); @(negedge clk);
    check("R8", 16'h0010);

    // R12: a strobe shows up right after the edge and stays set when removed
    ev = 7'h08;
    @(posedge clk); @(negedge clk);
    check("R12", 16'h1010);
    idle();
    @(posedge clk); @(negedge clk);
    check("R12", 16'h1010);

    // R10: a matching write with wr_en low clears nothing
    wr_en = 0; wr_be = 2'b11; wr_data = 16'hFFFF;
    @(posedge clk); @(negedge clk);
    check("R10", 16'h1010);
    idle();

    // R1: a reset in the middle of a run clears all sticky flags
    ev = 7'h7F; serr_en = 1; perr_resp = 1;
    @(posedge clk); @(negedge clk);
    check("R6", 16'hF910);
    idle();
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    check("R1", 16'h0010);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule